// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block drives the two-wire management bus of an external PHY using indirect-addressed Clause 45 frames. Software prepares two 16-bit holding registers, one for the register address inside the PHY and one for write data, then writes a command word. The command word starts exactly one serial frame. That frame is an address frame, a write frame or a read frame. A complete register access therefore takes two commands: an address frame, and then a read or write frame aimed at the same port and device.

While a frame is on the wire the block raises `busy`. The management clock is divided down from the system clock. Its half-period is computed from the system frequency so that it never exceeds 2.5 MHz. During a read the block lets go of the data line from the turnaround onward. It shifts in the PHY's 16 data bits on rising management-clock edges and places them in `rd_data` when the frame ends. If a command with the execute bit set arrives while a frame is running, the block drops that command and latches a sticky error flag.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset `busy`, `err_flag`, `mdc` and `mdio_oe` are 0 and `rd_data` is 16'h0000.
- R2: Writing `reg_sel`=2 sets the command word. Bit 15 is execute, bits 13:12 are the mode (3 = address, 1 = read, 2 = write), bits 9:5 are the port address and bits 4:0 are the device number. The frame sent is 32 ones, then 00, then the opcode (00 address, 01 write, 11 read), then port, device, turnaround and 16 data bits, all MSB first.
- R3: An address frame carries the value last written to `reg_sel`=0. The master drives the line for all 64 bits, including turnaround 10.
- R4: A write frame carries the value of the data register (`reg_sel`=1) at the moment the command is accepted. Writes to that register during the frame do not change the frame.
- R5: In a read frame `mdio_oe` is 0 from the first turnaround bit (bit 46) through bit 63. The 16 bits sampled on rising `mdc` edges, MSB first, appear in `rd_data` when `busy` returns to 0.
- R6: A read with no PHY driving the line samples the pull-up and gives `rd_data` = 16'hFFFF.
- R7: `busy` rises on the cycle after an accepted command and stays high for exactly 128×HALF system cycles (64 bits of 2×HALF cycles each).
- R8: `mdc` has a high phase and a low phase of HALF cycles each, where HALF = ceil(SYS_CLK_HZ / (2×MDC_MAX_HZ)). `mdc` is low whenever the block is idle.
- R9: A command with execute set that arrives while `busy` is 1 starts no frame and sets `err_flag`. `err_flag` stays 1 until reset.
- R10: A command with execute clear, or with mode 0, starts no frame and does not set `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 write data, 2 command, 3 unused |
| reg_wdata | input | 16 | Register write value |
| busy | output | 1 | A frame is in progress |
| err_flag | output | 1 | Sticky: a command arrived while busy |
| rd_data | output | 16 | Result of the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Serial data seen on the pad |

## Verification
A command is taken at the clock edge where the bench holds the strobe. `busy` and `err_flag` are therefore already valid at the next falling clock edge, and the bench checks them there. Over the following 128×HALF cycles the bench samples `busy` at falling edges and counts how many cycles it stays high. It reads `rd_data` on the first falling edge where `busy` is low, because the result is loaded on the same edge that ends the frame. A PHY model in the bench samples the line on each rising `mdc` and drives read data after each falling `mdc`. Frame contents and enable patterns are compared bit for bit against frames the bench builds on its own.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int WORD_W     = 16;
    localparam int TGT_W      = 10;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = PRE_BITS + 2 + 2 + TGT_W;   // first turnaround bit
    localparam int DATA_IDX   = TA_IDX + 2;                 // first data bit

    typedef enum logic [1:0] {
        OPM_NONE  = 2'd0,
        OPM_READ  = 2'd1,
        OPM_WRITE = 2'd2,
        OPM_ADDR  = 2'd3
    } opmode_e;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_CMD   = 2'd2,
        SEL_SPARE = 2'd3
    } regsel_e;

    typedef struct packed {
        logic               exec;
        opmode_e            mode;
        logic [TGT_W-1:0]   target;
    } cmd_t;

    // Serial opcode placed after the start bits
    function automatic logic [1:0] wire_opcode(input opmode_e m);
        case (m)
            OPM_READ:  return 2'b11;
            OPM_WRITE: return 2'b01;
            default:   return 2'b00;
        endcase
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input opmode_e            m,
        input logic [TGT_W-1:0]   tgt,
        input logic [WORD_W-1:0]  payload
    );
        return {{PRE_BITS{1'b1}}, 2'b00, wire_opcode(m), tgt, 2'b10, payload};
    endfunction

    // Half-period of the management clock in system cycles, rounded up
    function automatic int unsigned mdc_half(input int unsigned sys_hz,
                                             input int unsigned max_hz);
        longint unsigned q;
        q = (longint'(sys_hz) + 2 * longint'(max_hz) - 1) / (2 * longint'(max_hz));
        if (q < 1) q = 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          phase_end;

    assign phase_end = run && (cnt_q == LAST);
    assign rise_stb  = phase_end && !mdc_q;
    assign fall_stb  = phase_end &&  mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (phase_end) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
    import mdio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [1:0]             reg_sel,
    input  logic [WORD_W-1:0]      reg_wdata,
    input  logic                   busy,
    output logic                   start,
    output logic                   start_read,
    output logic [FRAME_BITS-1:0]  start_frame,
    output logic                   err_flag
);
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              err_q;
    cmd_t              cmd;
    logic              cmd_wr;
    logic [WORD_W-1:0] payload;

    assign cmd_wr      = reg_we && (regsel_e'(reg_sel) == SEL_CMD);
    assign cmd.exec    = reg_wdata[15];
    assign cmd.mode    = opmode_e'(reg_wdata[13:12]);
    assign cmd.target  = reg_wdata[TGT_W-1:0];

    assign start       = cmd_wr && cmd.exec && (cmd.mode != OPM_NONE) && !busy;
    assign start_read  = (cmd.mode == OPM_READ);
    assign payload     = (cmd.mode == OPM_ADDR)  ? addr_q  :
                         (cmd.mode == OPM_WRITE) ? wdata_q : '0;
    assign start_frame = build_frame(cmd.mode, cmd.target, payload);
    assign err_flag    = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (reg_we && regsel_e'(reg_sel) == SEL_ADDR)  addr_q  <= reg_wdata;
            if (reg_we && regsel_e'(reg_sel) == SEL_WDATA) wdata_q <= reg_wdata;
            if (cmd_wr && cmd.exec && busy)                err_q   <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   start_read,
    input  logic [FRAME_BITS-1:0]  start_frame,
    input  logic                   rise_stb,
    input  logic                   fall_stb,
    input  logic                   mdio_i,
    output logic                   busy,
    output logic                   mdio_o,
    output logic                   mdio_oe,
    output logic [WORD_W-1:0]      rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q;
    logic                  rd_q;
    logic [WORD_W-1:0]     rdsh_q;
    logic [WORD_W-1:0]     rd_data_q;

    assign busy    = busy_q;
    assign mdio_o  = shreg_q[FRAME_BITS-1];
    assign mdio_oe = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));
    assign rd_data = rd_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q   <= '0;
            idx_q     <= '0;
            busy_q    <= 1'b0;
            rd_q      <= 1'b0;
            rdsh_q    <= '0;
            rd_data_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                shreg_q <= start_frame;
                idx_q   <= '0;
                rd_q    <= start_read;
                busy_q  <= 1'b1;
            end
        end else begin
            if (rise_stb && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
                rdsh_q <= {rdsh_q[WORD_W-2:0], mdio_i};
            if (fall_stb) begin
                shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                    rd_q   <= 1'b0;
                    if (rd_q) rd_data_q <= rdsh_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 10_000_000,
    parameter int unsigned MDC_MAX_HZ = 2_500_000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_we,
    input  logic [1:0]   reg_sel,
    input  logic [15:0]  reg_wdata,
    output logic         busy,
    output logic         err_flag,
    output logic [15:0]  rd_data,
    output logic         mdc,
    output logic         mdio_o,
    output logic         mdio_oe,
    input  logic         mdio_i
);
    localparam int unsigned HALF = mdc_half(SYS_CLK_HZ, MDC_MAX_HZ);

    logic                  start;
    logic                  start_read;
    logic [FRAME_BITS-1:0] start_frame;
    logic                  rise_stb;
    logic                  fall_stb;

    mdio_cmd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .busy        (busy),
        .start       (start),
        .start_read  (start_read),
        .start_frame (start_frame),
        .err_flag    (err_flag)
    );

    mdio_mdc_gen #(.HALF(HALF)) u_mdc (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_read  (start_read),
        .start_frame (start_frame),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .mdio_i      (mdio_i),
        .busy        (busy),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk
    import mdio_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 10_000_000,
    parameter int unsigned MDC_MAX_HZ = 2_500_000
) (
    input logic clk,
    input logic rst,
    input logic cmd_exec_wr,
    input logic cmd_mode_ok,
    input logic busy,
    input logic err_flag,
    input logic mdc,
    input logic mdio_oe
);
    localparam int unsigned HALF = mdc_half(SYS_CLK_HZ, MDC_MAX_HZ);

    logic        mdc_d;
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_d   <= 1'b0;
            run_len <= '0;
        end else begin
            mdc_d <= mdc;
            if (mdc != mdc_d) run_len <= '0;
            else              run_len <= run_len + 1'b1;
        end
    end

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_exec_wr && cmd_mode_ok));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!mdc && $past(mdc)));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(cmd_exec_wr && busy));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R8
    mdc_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc_d && !mdc) |-> (run_len == 16'(HALF - 1)));
endmodule

bind mdio_c45_master mdio_c45_master_chk #(
    .SYS_CLK_HZ (SYS_CLK_HZ),
    .MDC_MAX_HZ (MDC_MAX_HZ)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_exec_wr (reg_we && (reg_sel == 2'd2) && reg_wdata[15]),
    .cmd_mode_ok (reg_wdata[13:12] != 2'd0),
    .busy        (busy),
    .err_flag    (err_flag),
    .mdc         (mdc),
    .mdio_oe     (mdio_oe)
);

// File: tb/mdio_c45_master_bench.sv
module mdio_c45_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_HALF   = (10_000_000 + 2 * 2_500_000 - 1) / (2 * 2_500_000);
    localparam int FRAME_CYC  = 64 * 2 * EXP_HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic        busy, err_flag, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    int nchk  = 0;
    int nfail = 0;

    // PHY model state
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    int          nbits = 0;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b0;
    logic        phy_respond = 1'b0;
    logic [15:0] phy_val = 16'h0;
    logic        mdio_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_c45_master u_mdio_c45_master (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .err_flag  (err_flag),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    assign mdio_line = phy_en ? phy_bit : (mdio_oe ? mdio_o : 1'b1);
    assign mdio_i    = mdio_line;

    always @(posedge mdc) begin
        if (nbits < 64) begin
            cap[63-nbits]   = mdio_line;
            oecap[63-nbits] = mdio_oe;
            nbits++;
        end
    end

    always @(negedge mdc) begin
        if (phy_respond && nbits >= 48 && nbits < 64 && cap[29:28] == 2'b11) begin
            phy_en  = 1'b1;
            phy_bit = phy_val[63-nbits];
        end else begin
            phy_en = 1'b0;
        end
    end

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] prt,
                                              input logic [4:0] dev, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b00, op, prt, dev, 2'b10, d};
    endfunction

    function automatic logic [15:0] cmdw(input logic [1:0] mode, input logic [4:0] prt,
                                         input logic [4:0] dev);
        return {1'b1, 1'b0, mode, 2'b00, prt, dev};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic arm_capture();
        nbits = 0; cap = '0; oecap = '0; phy_en = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 4000) begin
            cyc++;
            @(negedge clk);
        end
        if (busy) chk("R7", "frame never ended", 64'(busy), 64'd0);
    endtask

    task automatic test_reset();
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "err_flag", 64'(err_flag), 64'd0);
        chk("R1", "rd_data", 64'(rd_data), 64'h0);
        chk("R1", "mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic test_noexec();
        arm_capture();
        reg_write(2'd2, {1'b0, 1'b0, 2'd3, 2'b00, 5'd1, 5'd1});
        repeat (20) @(negedge clk);
        chk("R10", "busy after no-exec", 64'(busy), 64'd0);
        reg_write(2'd2, cmdw(2'd0, 5'd1, 5'd1));
        repeat (20) @(negedge clk);
        chk("R10", "busy after mode 0", 64'(busy), 64'd0);
        chk("R10", "bits on wire", 64'(nbits), 64'd0);
        chk("R10", "err_flag", 64'(err_flag), 64'd0);
    endtask

    task automatic test_address();
        int cyc;
        reg_write(2'd0, 16'h1234);
        arm_capture();
        reg_write(2'd2, cmdw(2'd3, 5'h0A, 5'h01));
        wait_idle(cyc);
        chk("R7", "busy length", 64'(cyc), 64'(FRAME_CYC));
        chk("R2", "bit count", 64'(nbits), 64'd64);
        chk("R3", "address frame", cap, exp_frame(2'b00, 5'h0A, 5'h01, 16'h1234));
        chk("R3", "driven all bits", oecap, {64{1'b1}});
    endtask

    task automatic test_write();
        int cyc;
        reg_write(2'd0, 16'h0042);
        reg_write(2'd2, cmdw(2'd3, 5'h03, 5'h1E));
        wait_idle(cyc);
        reg_write(2'd1, 16'hBEEF);
        arm_capture();
        reg_write(2'd2, cmdw(2'd2, 5'h03, 5'h1E));
        repeat (30) @(negedge clk);
        reg_write(2'd1, 16'h0000);
        wait_idle(cyc);
        chk("R4", "write frame", cap, exp_frame(2'b01, 5'h03, 5'h1E, 16'hBEEF));
    endtask

    task automatic test_read();
        int cyc;
        phy_respond = 1'b1;
        phy_val     = 16'hA5C3;
        arm_capture();
        reg_write(2'd2, cmdw(2'd1, 5'h03, 5'h01));
        wait_idle(cyc);
        chk("R5", "rd_data", 64'(rd_data), 64'hA5C3);
        chk("R5", "enable pattern", oecap, {{46{1'b1}}, 18'd0});
        chk("R2", "read header", 64'(cap[63:18]),
            64'(exp_frame(2'b11, 5'h03, 5'h01, 16'h0) >> 18));
        phy_respond = 1'b0;
    endtask

    task automatic test_noresp();
        int cyc;
        phy_respond = 1'b0;
        arm_capture();
        reg_write(2'd2, cmdw(2'd1, 5'h07, 5'h01));
        wait_idle(cyc);
        chk("R6", "rd_data with no PHY", 64'(rd_data), 64'hFFFF);
    endtask

    task automatic test_mdc();
        int   run, runs, bad;
        logic prev;
        reg_write(2'd2, cmdw(2'd3, 5'h01, 5'h01));
        prev = mdc; run = 0; runs = 0; bad = 0;
        while (busy && runs < 1000) begin
            if (mdc == prev) run++;
            else begin
                if (run != EXP_HALF) bad++;
                runs++; prev = mdc; run = 1;
            end
            @(negedge clk);
        end
        if (run != EXP_HALF) bad++;
        runs++;
        chk("R8", "phase length errors", 64'(bad), 64'd0);
        chk("R8", "phase count", 64'(runs), 64'd128);
        repeat (10) @(negedge clk);
        chk("R8", "idle mdc", 64'(mdc), 64'd0);
    endtask

    task automatic test_busy_cmd();
        int cyc;
        reg_write(2'd0, 16'h5A5A);
        arm_capture();
        reg_write(2'd2, cmdw(2'd3, 5'h02, 5'h04));
        repeat (50) @(negedge clk);
        reg_write(2'd2, cmdw(2'd1, 5'h02, 5'h04));
        chk("R9", "err_flag set", 64'(err_flag), 64'd1);
        wait_idle(cyc);
        chk("R9", "frame unchanged", cap, exp_frame(2'b00, 5'h02, 5'h04, 16'h5A5A));
        repeat (300) @(negedge clk);
        chk("R9", "no extra frame", {63'(nbits), busy}, {63'd64, 1'b0});
        reg_write(2'd2, cmdw(2'd3, 5'h02, 5'h04));
        wait_idle(cyc);
        chk("R9", "err_flag sticky", 64'(err_flag), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_noexec();
        test_address();
        test_write();
        test_read();
        test_noresp();
        test_mdc();
        test_busy_cmd();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule